// File: doc/BRIEF.md
# Dual System Register I2C Slave

This block is a two-wire serial slave that holds the configuration for a dual-channel supply controller. The system clock oversamples SCL and SDA. The slave finds START and STOP conditions, shifts bits MSB first, and answers a 7-bit address. The upper six bits of that address are fixed. The lowest bit comes from a board-level select input. The slave pulls SDA low through an open-drain drive enable, both to acknowledge and to return read data.

Every write data byte goes to one of two registers. Bit 7 of the byte picks which one. Channel 1 keeps six writable bits and channel 2 keeps five. Reads return both registers in turn. Live overload and over-temperature flags take the read-only positions in the returned bytes. Both registers are held at zero while power-good is low. They are cleared again whenever the over-temperature flag rises. While power-good is low the slave acknowledges nothing.

Top module: `lnb_sysreg_i2c`

## Requirements
- R1: After reset, `ch1_cfg` and `ch2_cfg` are zero and `sda_drive_low` is low.
- R2: The slave responds only to address {000100, `addr_sel`}. A transfer to any other address gets no acknowledge and changes no register.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bytes are MSB first. The slave acknowledges an accepted address byte and each accepted write data byte by holding SDA low through the ninth SCL high phase.
- R4: A write data byte with bit 7 = 0 loads bits 6..1 into `ch1_cfg[5:0]`. Bit 0 of that byte is ignored.
- R5: A write data byte with bit 7 = 1 loads bits 6..2 into `ch2_cfg[4:0]`. Bits 1 and 0 of that byte are ignored.
- R6: Several data bytes in one write transfer are each routed by their own bit 7.
- R7: The channel 1 read byte is {0, `ch1_cfg`, `olf_ch1`}. The channel 2 read byte is {1, `ch2_cfg`, `otf`, `olf_ch2`}. Each is taken from the live flags when the byte starts.
- R8: In a read, the first byte after each address phase is channel 1. Each master ACK moves to the other register, and a master NACK ends the read.
- R9: While `pwr_good` is low, both registers are held at zero, no acknowledge is given and no write takes effect.
- R10: A rising edge of `otf` clears both registers.
- R11: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel | input | 1 | Address LSB select |
| pwr_good | input | 1 | Supply-good indication |
| olf_ch1 | input | 1 | Channel 1 overload flag |
| olf_ch2 | input | 1 | Channel 2 overload flag |
| otf | input | 1 | Over-temperature flag |
| ch1_cfg | output | 6 | Channel 1 settings, written from data bits 6..1 |
| ch2_cfg | output | 5 | Channel 2 settings, written from data bits 6..2 |

## Verification
The bench uses the default parameters: two synchronizer stages and a fixed upper address of 000100. One SCL quarter period lasts eight system clocks, so the three-cycle lag from the synchronizers and edge detection falls well inside each low phase. The bench drives `addr_sel` both ways, so both addresses can be hit and both can be missed. It also toggles `pwr_good` and `otf` between transfers, which exercises the clear paths and the status bits in the returned bytes.

// File: rtl/lnbi2c_pkg.sv
package lnbi2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CH1_W  = BYTE_W - 2;
  localparam int CH2_W  = BYTE_W - 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK_A,
    ST_ACK_B,
    ST_RDATA,
    ST_RREL,
    ST_RACK,
    ST_RNEXT
  } bus_state_t;
endpackage

// File: rtl/lnbi2c_sync.sv
module lnbi2c_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lnbi2c_engine.sv
module lnbi2c_engine
  import lnbi2c_pkg::*;
#(
  parameter logic [5:0] ADDR_UPPER = 6'b000100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic              pwr_good,
  input  logic [BYTE_W-1:0] rd_byte_a,
  input  logic [BYTE_W-1:0] rd_byte_b,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  logic scl_d, sda_d;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  bus_state_t st_q, st_n;
  logic [2:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n;
  logic              sel_q, sel_n;
  logic              oe_q, oe_n;
  logic [BYTE_W-1:0] byte_in;
  logic [BYTE_W-1:0] cur_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign byte_in  = {sh_q[BYTE_W-2:0], sda_s};
  assign cur_rd   = sel_q ? rd_byte_b : rd_byte_a;
  assign wr_data  = byte_in;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    rw_n  = rw_q;
    sel_n = sel_q;
    oe_n  = oe_q;
    wr_en = 1'b0;
    if (start_ev) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_ev) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise) begin
          sh_n  = byte_in;
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (byte_in[BYTE_W-1:1] == {ADDR_UPPER, addr_sel} && pwr_good) begin
              rw_n  = byte_in[0];
              sel_n = 1'b0;
              st_n  = ST_ACK_A;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_WDATA: if (scl_rise) begin
          sh_n  = byte_in;
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (pwr_good) begin
              wr_en = 1'b1;
              st_n  = ST_ACK_A;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ACK_A: if (scl_fall) begin
          oe_n = 1'b1;
          st_n = ST_ACK_B;
        end
        ST_ACK_B: if (scl_fall) begin
          cnt_n = '0;
          if (rw_q) begin
            sh_n = cur_rd;
            oe_n = ~cur_rd[BYTE_W-1];
            st_n = ST_RDATA;
          end else begin
            oe_n = 1'b0;
            st_n = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) st_n = ST_RREL;
          end else if (scl_fall) begin
            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
            oe_n = ~sh_q[BYTE_W-2];
          end
        end
        ST_RREL: if (scl_fall) begin
          oe_n = 1'b0;
          st_n = ST_RACK;
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_s) begin
            sel_n = ~sel_q;
            st_n  = ST_RNEXT;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_RNEXT: if (scl_fall) begin
          cnt_n = '0;
          sh_n  = cur_rd;
          oe_n  = ~cur_rd[BYTE_W-1];
          st_n  = ST_RDATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rw_q  <= 1'b0;
      sel_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      rw_q  <= rw_n;
      sel_q <= sel_n;
      oe_q  <= oe_n;
    end
  end

  assign sda_oe = oe_q;

  // R11: the drive enable never moves while the synchronized SCL is high
  p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);
  // R9: no register write is issued without power-good
  p_write_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pwr_good);
  // R3: an issued write is followed by the acknowledge phase
  p_write_then_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (st_q == ST_ACK_A));
endmodule

// File: rtl/lnbi2c_regs.sv
module lnbi2c_regs
  import lnbi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              otf,
  input  logic              olf1,
  input  logic              olf2,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CH1_W-1:0]  cfg1,
  output logic [CH2_W-1:0]  cfg2,
  output logic [BYTE_W-1:0] rd_byte_a,
  output logic [BYTE_W-1:0] rd_byte_b
);
  logic             otf_q;
  logic             ovt_rise, clr;
  logic [CH1_W-1:0] cfg1_q, cfg1_n;
  logic [CH2_W-1:0] cfg2_q, cfg2_n;
  logic             unused_bit0;

  assign unused_bit0 = wr_data[0];
  assign ovt_rise    = otf & ~otf_q;
  assign clr         = ~pwr_good | ovt_rise;

  always_comb begin
    cfg1_n = cfg1_q;
    cfg2_n = cfg2_q;
    if (clr) begin
      cfg1_n = '0;
      cfg2_n = '0;
    end else if (wr_en) begin
      if (wr_data[BYTE_W-1]) cfg2_n = wr_data[BYTE_W-2:2];
      else                   cfg1_n = wr_data[BYTE_W-2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      otf_q  <= 1'b0;
      cfg1_q <= '0;
      cfg2_q <= '0;
    end else begin
      otf_q  <= otf;
      cfg1_q <= cfg1_n;
      cfg2_q <= cfg2_n;
    end
  end

  assign cfg1      = cfg1_q;
  assign cfg2      = cfg2_q;
  assign rd_byte_a = {1'b0, cfg1_q, olf1};
  assign rd_byte_b = {1'b1, cfg2_q, otf, olf2};

  // R9: registers read zero one cycle after power-good is low
  p_powerdown_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (cfg1 == '0 && cfg2 == '0));
  // R10: registers read zero after the over-temperature flag rises
  p_overtemp_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otf) |=> (cfg1 == '0 && cfg2 == '0));
endmodule

// File: rtl/lnb_sysreg_i2c.sv
module lnb_sysreg_i2c
  import lnbi2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_UPPER  = 6'b000100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_drive_low,
  input  logic             addr_sel,
  input  logic             pwr_good,
  input  logic             olf_ch1,
  input  logic             olf_ch2,
  input  logic             otf,
  output logic [CH1_W-1:0] ch1_cfg,
  output logic [CH2_W-1:0] ch2_cfg
);
  logic [1:0]        lines_s;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_byte_a, rd_byte_b;

  lnbi2c_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_s)
  );

  lnbi2c_engine #(.ADDR_UPPER(ADDR_UPPER)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .addr_sel  (addr_sel),
    .pwr_good  (pwr_good),
    .rd_byte_a (rd_byte_a),
    .rd_byte_b (rd_byte_b),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_oe    (sda_drive_low)
  );

  lnbi2c_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .otf       (otf),
    .olf1      (olf_ch1),
    .olf2      (olf_ch2),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg1      (ch1_cfg),
    .cfg2      (ch2_cfg),
    .rd_byte_a (rd_byte_a),
    .rd_byte_b (rd_byte_b)
  );
endmodule

// File: tb/lnb_sysreg_i2c_bench.sv
module lnb_sysreg_i2c_bench;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rst_n, scl, sda_m, addr_sel, pwr_good, olf1, olf2, otf;
  logic sda_oe;
  logic [5:0] ch1_cfg;
  logic [4:0] ch2_cfg;
  logic sda_line;

  int total = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_en = 0;
  int e1 = 0;
  int e2 = 0;
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  lnb_sysreg_i2c u_lnb_sysreg_i2c (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_oe), .addr_sel(addr_sel), .pwr_good(pwr_good),
    .olf_ch1(olf1), .olf_ch2(olf2), .otf(otf),
    .ch1_cfg(ch1_cfg), .ch2_cfg(ch2_cfg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison of register outputs (R4 R5 R6 R9 R10)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      total++;
      if (int'(ch1_cfg) != e1 || int'(ch2_cfg) != e2) begin
        fails++;
        $display("FAIL R4/R5 regs actual %0h %0h expected %0h %0h", ch1_cfg, ch2_cfg, e1, e2);
      end
    end
  end

  // R11 monitor: drive enable moves only while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe) begin
      total++;
      if (scl !== 1'b0) begin
        fails++;
        $display("FAIL R11 sda change scl actual %0b expected 0", scl);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic qtr();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; qtr(); scl = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl = 1'b0; qtr();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; qtr(); scl = 1'b1; qtr(); sda_m = 1'b1; qtr();
  endtask

  task automatic m_bit(input logic b, output logic seen);
    sda_m = b; qtr(); scl = 1'b1; qtr(); seen = sda_line; qtr(); scl = 1'b0; qtr();
  endtask

  task automatic m_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic m_rd(output logic [7:0] b, input logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      b[i] = s;
    end
    m_bit(~ack, s);
  endtask

  function automatic void model_wr(input logic [7:0] d);
    if (d[7]) e2 = int'(d[6:2]);
    else      e1 = int'(d[6:1]);
  endfunction

  task automatic wr1(input logic [6:0] a, input logic [7:0] d, input logic exp_ack);
    logic ak;
    cmp_en = 0;
    m_start();
    m_byte({a, 1'b0}, ak);
    chk("R2 address ack", int'(ak), int'(exp_ack));
    m_byte(d, ak);
    chk("R3 data ack", int'(ak), int'(exp_ack));
    m_stop();
    if (exp_ack) model_wr(d);
    cmp_en = 1;
  endtask

  task automatic settle_clear();
    repeat (2) @(negedge clk);
    e1 = 0; e2 = 0;
    cmp_en = 1;
  endtask

  initial begin
    logic ak;
    logic [7:0] rb;
    rst_n = 0; scl = 1; sda_m = 1; addr_sel = 0; pwr_good = 1;
    olf1 = 0; olf2 = 0; otf = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ch1_cfg", int'(ch1_cfg), 0);
    chk("R1 ch2_cfg", int'(ch2_cfg), 0);
    chk("R1 sda_drive_low", int'(sda_oe), 0);
    cmp_en = 1;

    // R4: channel 1 write, bit0 ignored
    wr1(7'h08, 8'h7F, 1'b1);
    chk("R4 ch1 all ones", int'(ch1_cfg), 6'h3F);
    // R5: channel 2 write, bits 1:0 ignored
    wr1(7'h08, 8'hFF, 1'b1);
    chk("R5 ch2 all ones", int'(ch2_cfg), 5'h1F);

    // R7: readback shows ignored bits replaced by status
    cmp_en = 0;
    m_start(); m_byte(8'h11, ak);
    chk("R3 read address ack", int'(ak), 1);
    m_rd(rb, 1'b1); chk("R7 ch1 byte", int'(rb), 8'h7E);
    m_rd(rb, 1'b0); chk("R7 ch2 byte", int'(rb), 8'hFC);
    m_stop();
    cmp_en = 1;

    // R6: two data bytes in one transfer
    cmp_en = 0;
    m_start(); m_byte(8'h10, ak);
    m_byte(8'h2A, ak); chk("R6 first byte ack", int'(ak), 1);
    m_byte(8'h94, ak); chk("R6 second byte ack", int'(ak), 1);
    m_stop();
    model_wr(8'h2A); model_wr(8'h94);
    cmp_en = 1;
    chk("R6 ch1", int'(ch1_cfg), 6'h15);
    chk("R6 ch2", int'(ch2_cfg), 5'h05);

    // R7 R8: status merge, alternation, NACK end, restart at channel 1
    olf1 = 1; olf2 = 1;
    cmp_en = 0;
    m_start(); m_byte(8'h11, ak);
    m_rd(rb, 1'b1); chk("R7 ch1 with olf", int'(rb), 8'h2B);
    m_rd(rb, 1'b1); chk("R8 second is ch2", int'(rb), 8'h95);
    m_rd(rb, 1'b0); chk("R8 third is ch1", int'(rb), 8'h2B);
    m_stop();
    m_start(); m_byte(8'h11, ak);
    m_rd(rb, 1'b0); chk("R8 restart at ch1", int'(rb), 8'h2B);
    m_stop();
    cmp_en = 1;
    olf1 = 0; olf2 = 0;

    // R2: address select moves the response
    addr_sel = 1;
    wr1(7'h08, 8'h40, 1'b0);
    wr1(7'h09, 8'h02, 1'b1);
    chk("R2 alternate address write", int'(ch1_cfg), 6'h01);
    addr_sel = 0;
    wr1(7'h09, 8'h7E, 1'b0);
    wr1(7'h4A, 8'h7E, 1'b0);

    // R9: power-good low clears and blocks
    wr1(7'h08, 8'hFC, 1'b1);
    cmp_en = 0; pwr_good = 0; settle_clear();
    chk("R9 cleared ch2", int'(ch2_cfg), 0);
    wr1(7'h08, 8'h7E, 1'b0);
    pwr_good = 1;
    repeat (4) @(negedge clk);
    chk("R9 no write while unpowered", int'(ch1_cfg), 0);

    // R10: over-temperature rise clears
    wr1(7'h08, 8'h7E, 1'b1);
    wr1(7'h08, 8'hFC, 1'b1);
    cmp_en = 0; otf = 1; settle_clear();
    chk("R10 cleared ch1", int'(ch1_cfg), 0);
    cmp_en = 0;
    m_start(); m_byte(8'h11, ak);
    m_rd(rb, 1'b1); chk("R10 ch1 read", int'(rb), 8'h00);
    m_rd(rb, 1'b0); chk("R10 ch2 read shows otf", int'(rb), 8'h82);
    m_stop();
    cmp_en = 1;
    wr1(7'h08, 8'h06, 1'b1);
    chk("R10 write after clear", int'(ch1_cfg), 6'h03);
    otf = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule